// File: doc/BRIEF.md
# Down-Counting Interval Timer

This block is a 32-bit interval timer that sits on a plain word-addressed register bus. Software loads a period, which is copied straight into the live counter. It then issues a start command through the control word. The counter steps down by one on every clock cycle in which the tick input is high. When the count runs out, a sticky timeout flag is raised. In continuous mode the counter then refills from the period and keeps counting. In one-shot mode it halts.

The interrupt line is a level: it is high while the timeout flag is set and interrupts are enabled in the control word. Writing the status word clears the flag. The live count can be read at any time through the snapshot word. Start and stop are command bits inside the control word. Stop wins when both are set.

Top module: `interval_timer`

## Requirements
- R1: The word index is taken from address bits [3:2]: 0 is status, 1 is control, 2 is period, 3 is snapshot. Address bits [1:0] are ignored. Any address with a nonzero bit above bit 3 is unmapped.
- R2: A status read returns the timeout flag in bit 0 and the running state in bit 1. Bits 31:2 read zero.
- R3: A control write stores the whole 32-bit word, and a control read returns it unchanged. In that word, bit 0 enables the interrupt, bit 1 selects continuous mode, bit 2 is start and bit 3 is stop.
- R4: A write of any value to status clears only the timeout flag, from the next cycle on. Running, count and control are left as they were. If an expiry happens in the same cycle, the flag stays set.
- R5: A period write stores the value. From the next cycle the live counter holds that value, which takes priority over any tick in the same cycle.
- R6: While running, each cycle with tick high lowers the count by one. A tick that arrives while the count is 1 or 0 is an expiry and sets the timeout flag. Without tick, or while stopped, the count holds.
- R7: On an expiry in continuous mode, the count reloads from the period and counting goes on. In one-shot mode, the count becomes 0 and running clears.
- R8: The irq output equals the timeout flag ANDed with the interrupt-enable bit. It reflects a write or an expiry from the following cycle.
- R9: A control write with start set begins counting. A control write with stop set halts counting, and a write with both set leaves the timer stopped.
- R10: After reset, all four registers read zero, the timer is stopped and irq is low.
- R11: A snapshot read returns the live count. Writes to snapshot and to unmapped addresses change nothing. Reads of unmapped addresses return zero, and rdata is zero in any cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| bus_valid | input | 1 | Bus access valid this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, zero when not reading |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume at most one bus access per cycle, with every access a full word. They also assume that tick and the bus inputs are stable across each clock edge. The stimulus drives every input on the falling edge, one access per step, from a single task. It then compares the outputs against a behavioural model just after that edge. The sequences deliberately place writes and expiries in the same cycle, so the priority rules between them are exercised inside those limits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 2;

    typedef enum logic [IDX_W-1:0] {
        IDX_STATUS = 2'd0,
        IDX_CTRL   = 2'd1,
        IDX_PERIOD = 2'd2,
        IDX_SNAP   = 2'd3
    } reg_idx_e;

    // control word, bit 0 is the last member
    typedef struct packed {
        logic [DATA_W-5:0] spare;
        logic              stop;
        logic              start;
        logic              cont;
        logic              irq_en;
    } ctrl_word_t;

    typedef struct packed {
        logic status;
        logic ctrl;
        logic period;
        logic snap;
    } wr_strobe_t;

    function automatic logic [DATA_W-1:0] status_word(input logic flag, input logic run);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[0] = flag;
        w[1] = run;
        return w;
    endfunction

    function automatic logic is_expiry(input logic run, input logic tk,
                                       input logic [DATA_W-1:0] cnt);
        return run && tk && (cnt <= DATA_W'(1));
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output wr_strobe_t        wr,
    output logic              rd_en,
    output logic              rd_hit,
    output reg_idx_e          rd_idx
);
    localparam int LO_W = 2;

    logic     mapped;
    reg_idx_e idx;
    logic     unused_lo;

    assign unused_lo = ^addr[LO_W-1:0];
    assign idx       = reg_idx_e'(addr[LO_W+IDX_W-1:LO_W]);

    generate
        if (ADDR_W > LO_W + IDX_W) begin : g_upper
            assign mapped = (addr[ADDR_W-1:LO_W+IDX_W] == '0);
        end else begin : g_full
            assign mapped = 1'b1;
        end
    endgenerate

    always_comb begin
        wr = '0;
        if (valid && write && mapped) begin
            unique case (idx)
                IDX_STATUS: wr.status = 1'b1;
                IDX_CTRL:   wr.ctrl   = 1'b1;
                IDX_PERIOD: wr.period = 1'b1;
                IDX_SNAP:   wr.snap   = 1'b1;
            endcase
        end
    end

    assign rd_en  = valid && !write;
    assign rd_hit = rd_en && mapped;
    assign rd_idx = idx;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic              cont,
    input  logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] count,
    output logic              running,
    output logic              expire
);
    logic [DATA_W-1:0] count_d;
    logic              run_d;

    assign expire = is_expiry(running, tick, count);

    always_comb begin
        count_d = count;
        if (load_en) begin
            count_d = load_val;
        end else if (expire) begin
            count_d = cont ? period : '0;
        end else if (running && tick) begin
            count_d = count - DATA_W'(1);
        end
    end

    always_comb begin
        run_d = running;
        if (stop_cmd) begin
            run_d = 1'b0;
        end else if (start_cmd) begin
            run_d = 1'b1;
        end else if (expire && !cont) begin
            run_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
        end else begin
            count   <= count_d;
            running <= run_d;
        end
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output ctrl_word_t        ctrl,
    output logic [DATA_W-1:0] period,
    output logic              flag,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            period <= '0;
        end else begin
            if (wr.ctrl) begin
                ctrl <= ctrl_word_t'(wdata);
            end
            if (wr.period) begin
                period <= wdata;
            end
        end
    end

    // an expiry outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (wr.status) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && ctrl.irq_en;
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
(
    input  logic              rd_hit,
    input  reg_idx_e          rd_idx,
    input  logic              flag,
    input  logic              running,
    input  ctrl_word_t        ctrl,
    input  logic [DATA_W-1:0] period,
    input  logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            unique case (rd_idx)
                IDX_STATUS: rdata = status_word(flag, running);
                IDX_CTRL:   rdata = DATA_W'(ctrl);
                IDX_PERIOD: rdata = period;
                IDX_SNAP:   rdata = count;
            endcase
        end
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    wr_strobe_t        wr_w;
    logic              rd_en_w;
    logic              rd_hit_w;
    reg_idx_e          rd_idx_w;
    ctrl_word_t        ctrl_w;
    ctrl_word_t        wctrl_w;
    logic [DATA_W-1:0] period_w;
    logic [DATA_W-1:0] count_w;
    logic              run_w;
    logic              flag_w;
    logic              expire_w;
    logic              ie_w;
    logic              unused_rd;

    assign wctrl_w   = ctrl_word_t'(bus_wdata);
    assign ie_w      = ctrl_w.irq_en;
    assign unused_rd = rd_en_w ^ wr_w.snap;

    tmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .valid  (bus_valid),
        .write  (bus_write),
        .addr   (bus_addr),
        .wr     (wr_w),
        .rd_en  (rd_en_w),
        .rd_hit (rd_hit_w),
        .rd_idx (rd_idx_w)
    );

    tmr_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load_en   (wr_w.period),
        .load_val  (bus_wdata),
        .start_cmd (wr_w.ctrl && wctrl_w.start),
        .stop_cmd  (wr_w.ctrl && wctrl_w.stop),
        .cont      (ctrl_w.cont),
        .period    (period_w),
        .count     (count_w),
        .running   (run_w),
        .expire    (expire_w)
    );

    tmr_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_w),
        .wdata  (bus_wdata),
        .expire (expire_w),
        .ctrl   (ctrl_w),
        .period (period_w),
        .flag   (flag_w),
        .irq    (irq)
    );

    tmr_rdmux u_rdmux (
        .rd_hit  (rd_hit_w),
        .rd_idx  (rd_idx_w),
        .flag    (flag_w),
        .running (run_w),
        .ctrl    (ctrl_w),
        .period  (period_w),
        .count   (count_w),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic [31:0]       count,
    input logic              running,
    input logic              flag,
    input logic              irq_en,
    input logic              cont
);
    logic mapped, wr_stat, wr_ctrl, wr_per, rd_stat;

    assign mapped  = (bus_addr >> 4) == '0;
    assign wr_stat = bus_valid && bus_write && mapped && bus_addr[3:2] == 2'd0;
    assign wr_ctrl = bus_valid && bus_write && mapped && bus_addr[3:2] == 2'd1;
    assign wr_per  = bus_valid && bus_write && mapped && bus_addr[3:2] == 2'd2;
    assign rd_stat = bus_valid && !bus_write && mapped && bus_addr[3:2] == 2'd0;

    p_status_pad_r2: assert property (@(posedge clk) disable iff (rst)
        rd_stat |-> bus_rdata[31:2] == 30'd0);

    p_clear_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !tick) |=> (!flag && !irq));

    p_period_load_r5: assert property (@(posedge clk) disable iff (rst)
        wr_per |=> count == $past(bus_wdata));

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        (running && tick && count > 32'd1 && !wr_per) |=> count == $past(count) - 32'd1);

    p_count_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_per) |=> $stable(count));

    p_oneshot_end_r7: assert property (@(posedge clk) disable iff (rst)
        (running && tick && count <= 32'd1 && !cont && !wr_ctrl) |=> (!running && flag));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && irq_en));

    p_stop_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[3]) |=> !running);

    p_start_runs_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[2] && !bus_wdata[3]) |=> running);

    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |-> bus_rdata == 32'd0);
endmodule

bind interval_timer tmr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count     (count_w),
    .running   (run_w),
    .flag      (flag_w),
    .irq_en    (ie_w),
    .cont      (ctrl_w.cont)
);

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int tests = 0;
    int fails = 0;

    // reference state
    bit [31:0] m_ctrl, m_period, m_count;
    bit        m_run, m_flag;

    always #2 clk = ~clk;

    interval_timer #(.ADDR_W(AW)) u_interval_timer (
        .clk(clk), .rst(rst), .tick(tick), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic bit [31:0] m_read(input bit [AW-1:0] a);
        if ((a >> 4) != 0) return 32'd0;
        case (a[3:2])
            2'd0:    return {30'd0, m_run, m_flag};
            2'd1:    return m_ctrl;
            2'd2:    return m_period;
            default: return m_count;
        endcase
    endfunction

    task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_ctrl = 0; m_period = 0; m_count = 0; m_run = 0; m_flag = 0;
    endtask

    // one cycle: drive, compare against current model, advance model
    task automatic step(input bit v, input bit w, input bit [AW-1:0] a,
                        input bit [31:0] d, input bit t, input string tag);
        bit mapped, expd;
        bit [31:0] nc;
        bit nr, nf;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; tick = t;
        #1;
        check("R8 irq", {31'd0, irq}, {31'd0, m_flag & m_ctrl[0]});
        if (v && !w) check(tag, bus_rdata, m_read(a));
        else         check("R11 idle rdata", bus_rdata, 32'd0);
        mapped = (a >> 4) == 0;
        expd   = m_run && t && (m_count <= 1);
        nc = m_count; nr = m_run; nf = m_flag;
        if (expd) nc = m_ctrl[1] ? m_period : 32'd0;
        else if (m_run && t) nc = m_count - 1;
        if (expd && !m_ctrl[1]) nr = 0;
        if (expd) nf = 1;
        if (v && w && mapped) begin
            case (a[3:2])
                2'd0: if (!expd) nf = 0;
                2'd1: begin
                    m_ctrl = d;
                    if (d[2]) nr = 1;
                    if (d[3]) nr = 0;
                end
                2'd2: begin m_period = d; nc = d; end
                default: ;
            endcase
        end
        m_count = nc; m_run = nr; m_flag = nf;
    endtask

    task automatic wr(input bit [AW-1:0] a, input bit [31:0] d, input bit t);
        step(1, 1, a, d, t, "");
    endtask
    task automatic rd(input bit [AW-1:0] a, input bit t, input string tag);
        step(1, 0, a, 0, t, tag);
    endtask
    task automatic idle(input bit t);
        step(0, 0, 0, 0, t, "");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R10 reset state
        rd(6'h00, 0, "R10 status"); rd(6'h04, 0, "R10 control");
        rd(6'h08, 0, "R10 period"); rd(6'h0C, 0, "R10 snapshot");
        // R5 period load, R3 readback
        wr(6'h08, 32'd5, 0);
        rd(6'h0C, 0, "R5 snapshot after period");
        rd(6'h08, 0, "R5 period");
        // R9 start one-shot with irq enable, R6 R7 countdown
        wr(6'h04, 32'hABCD_0005, 0);
        rd(6'h04, 0, "R3 control word");
        rd(6'h00, 0, "R9 running");
        for (int i = 0; i < 7; i++) rd(6'h0C, 1, "R6 countdown");
        rd(6'h00, 1, "R7 one-shot halted");
        // R4 clear flag
        wr(6'h00, 32'hFFFF_FFFF, 0);
        rd(6'h00, 0, "R4 cleared");
        // R7 continuous with sparse ticks
        wr(6'h08, 32'd3, 0);
        wr(6'h04, 32'h0000_0007, 1);
        for (int i = 0; i < 16; i++) rd(6'h0C, (i % 3) != 1, "R7 reload");
        rd(6'h00, 0, "R2 status bits");
        // R4 clear in the same cycle as an expiry
        wr(6'h08, 32'd1, 0);
        wr(6'h00, 32'd0, 1);
        rd(6'h00, 0, "R4 expiry wins");
        // R9 stop precedence
        wr(6'h04, 32'h0000_000F, 1);
        rd(6'h00, 1, "R9 stop wins");
        rd(6'h0C, 1, "R9 count frozen");
        wr(6'h04, 32'h0000_0008, 0);
        rd(6'h00, 0, "R9 stop only");
        // R11 snapshot write and unmapped ignored, R1 low bits ignored
        wr(6'h0C, 32'h1234_5678, 0);
        wr(6'h14, 32'hFFFF_FFFF, 0);
        wr(6'h38, 32'h0000_0004, 0);
        rd(6'h0C, 0, "R11 snapshot kept");
        rd(6'h08, 0, "R11 period kept");
        rd(6'h20, 0, "R11 unmapped zero");
        rd(6'h09, 0, "R1 byte offset");
        rd(6'h06, 0, "R1 control offset");
        // period zero continuous: expiry every tick
        wr(6'h08, 32'd0, 0);
        wr(6'h04, 32'h0000_0006, 0);
        for (int i = 0; i < 4; i++) rd(6'h00, 1, "R6 zero period");
        // period rewrite while running, tick same cycle
        wr(6'h08, 32'd9, 1);
        for (int i = 0; i < 4; i++) rd(6'h0C, 1, "R5 reload running");
        wr(6'h04, 32'h0000_0001, 0);
        idle(1);
        // reset mid-run
        @(negedge clk); rst = 1'b1; tick = 1'b0; bus_valid = 1'b0;
        @(negedge clk); rst = 1'b0; m_reset();
        rd(6'h00, 0, "R10 status after reset");
        rd(6'h0C, 0, "R10 count after reset");
        idle(0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule